// File: doc/BRIEF.md
# Looping Descriptor Pulse Sequencer

The block drives a bank of output pins with repeating pulse trains, such as servo control pulses. It does not give each channel its own counter. Instead it steps through a small list of descriptors held in local storage. Each descriptor either raises a group of pins, lowers a group of pins, does nothing for one cycle, or stalls until the next pacing tick. Every descriptor names the entry that follows it, so the list closes on itself and runs without any host action once it has been started.

Pacing ticks come from a divider on the system clock. The host sets the divider length, which is the time quantum. Pulse widths and periods are whole numbers of quanta, fixed by how many stall entries lie between a raise and a lower. The host fills the list through a single-entry write port. To change a pulse width while the list is running, it rewrites individual entries, and each new entry is used the next time the sequencer reaches it.

A run control starts and stops the block. While the control is low, all pins are low, the sequencer points at entry 0 and the pacer is cleared. The stored list is kept.

Top module: `pulse_seq`

## Requirements
- R1: After reset all pins are low. When run is raised, entry 0 executes on the first clock edge that sees run high, and its pin effect is visible after that edge.
- R2: The opcode is 2 bits: 0 = no-op, 1 = raise, 2 = lower, 3 = stall. A raise ORs its mask into the pins and a lower clears the mask bits from the pins, both one cycle after the entry executes. A no-op or a stall leaves every pin unchanged.
- R3: Each raise, lower or no-op entry takes exactly one cycle. The sequencer then continues at the entry named in that descriptor's 5-bit next field, whatever that index is.
- R4: The pacer ticks on every (div_val+1)-th cycle, counted from the first cycle of a run, and the first tick falls on cycle div_val+1. A stall entry completes in a cycle with a tick and otherwise holds the sequencer where it is.
- R5: A list of one raise, h stalls, one lower and T-h further stalls, closed back to entry 0, gives a pulse that is exactly h*(div_val+1) cycles high and repeats every T*(div_val+1) cycles. This holds when each run of non-stall entries is shorter than one quantum.
- R6: Several pins share one list. A common raise followed by separate lower entries gives each pin its own width, all with the same period.
- R7: An entry written while the sequencer runs is used from its next fetch onward. A pass through the list that has already passed that entry keeps its old timing.
- R8: While run is low, the pins go low and the sequencer returns to entry 0 one cycle later, and the pacer restarts. The list is retained, so a new run repeats the timing of a fresh start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Start (1) or stop (0) the sequencer |
| div_val | input | DIV_W | Pacing quantum minus one, in clock cycles |
| wr_en | input | 1 | Write one descriptor this cycle |
| wr_addr | input | IDX_W | Index of the descriptor being written |
| wr_op | input | 2 | Opcode of the written descriptor |
| wr_mask | input | N_OUT | Pin mask of the written descriptor |
| wr_next | input | IDX_W | Successor index of the written descriptor |
| pins | output | N_OUT | Registered output pin bank |

## Verification
If the entry pointer goes wrong, the pins show a width or period that is off by whole quanta, or by single cycles, within the first pass through the list. If the pacer count is off, every stall stretches or shrinks, so a width error grows in proportion to the number of stalls and is visible at the first falling edge. A wrong mask update shows on the pins one cycle after the faulty entry executes. A fault in the stop path shows at the first cycle after run drops, or as a shifted first edge on the following run.

// File: rtl/pseq_pkg.sv
package pseq_pkg;
  typedef enum logic [1:0] {
    OP_NOP  = 2'd0,
    OP_SET  = 2'd1,
    OP_CLR  = 2'd2,
    OP_WAIT = 2'd3
  } seq_op_e;
endpackage

// File: rtl/pseq_rst_sync.sv
module pseq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      rst_s_n <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_s_n <= stage_q;
    end
  end
endmodule

// File: rtl/pseq_desc_mem.sv
module pseq_desc_mem #(
  parameter int N_OUT = 8,
  parameter int DEPTH = 32,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [1:0]       wr_op,
  input  logic [N_OUT-1:0] wr_mask,
  input  logic [IDX_W-1:0] wr_next,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [1:0]       rd_op,
  output logic [N_OUT-1:0] rd_mask,
  output logic [IDX_W-1:0] rd_next
);
  logic [1:0]       op_q   [DEPTH];
  logic [N_OUT-1:0] mask_q [DEPTH];
  logic [IDX_W-1:0] next_q [DEPTH];

  // One write per cycle; each entry has its own written-out enable.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        op_q[i]   <= 2'd0;
        mask_q[i] <= '0;
        next_q[i] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (wr_en && (wr_addr == IDX_W'(i))) begin
          op_q[i]   <= wr_op;
          mask_q[i] <= wr_mask;
          next_q[i] <= wr_next;
        end
      end
    end
  end

  // Combinational fetch: a write lands before the next fetch of that entry.
  always_comb begin
    rd_op   = op_q[rd_idx];
    rd_mask = mask_q[rd_idx];
    rd_next = next_q[rd_idx];
  end
endmodule

// File: rtl/pseq_pacer.sv
module pseq_pacer #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  output logic             tick
);
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;
  logic             wrap;

  assign wrap = (cnt_q >= div_val);
  assign tick = run && wrap;

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = '0;
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/pseq_engine.sv
module pseq_engine
  import pseq_pkg::*;
#(
  parameter int N_OUT = 8,
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic [1:0]       cur_op,
  input  logic [N_OUT-1:0] cur_mask,
  input  logic [IDX_W-1:0] cur_next,
  output logic [IDX_W-1:0] ptr,
  output logic [N_OUT-1:0] pins
);
  seq_op_e          op;
  logic [IDX_W-1:0] ptr_q, ptr_d;
  logic [N_OUT-1:0] pins_q, pins_d;

  assign op = seq_op_e'(cur_op);

  always_comb begin
    ptr_d  = ptr_q;
    pins_d = pins_q;
    if (!run) begin
      ptr_d  = '0;
      pins_d = '0;
    end else begin
      case (op)
        OP_SET: begin
          pins_d = pins_q | cur_mask;
          ptr_d  = cur_next;
        end
        OP_CLR: begin
          pins_d = pins_q & ~cur_mask;
          ptr_d  = cur_next;
        end
        OP_WAIT: begin
          if (tick) ptr_d = cur_next;
        end
        default: begin
          ptr_d = cur_next;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q  <= '0;
      pins_q <= '0;
    end else begin
      ptr_q  <= ptr_d;
      pins_q <= pins_d;
    end
  end

  assign ptr  = ptr_q;
  assign pins = pins_q;
endmodule

// File: rtl/pulse_seq.sv
module pulse_seq #(
  parameter int N_OUT = 8,
  parameter int DEPTH = 32,
  parameter int DIV_W = 16,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div_val,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_addr,
  input  logic [1:0]       wr_op,
  input  logic [N_OUT-1:0] wr_mask,
  input  logic [IDX_W-1:0] wr_next,
  output logic [N_OUT-1:0] pins
);
  logic             rst_s_n;
  logic             tick;
  logic [IDX_W-1:0] ptr;
  logic [1:0]       cur_op;
  logic [N_OUT-1:0] cur_mask;
  logic [IDX_W-1:0] cur_next;

  pseq_rst_sync u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_s_n (rst_s_n)
  );

  pseq_desc_mem #(.N_OUT(N_OUT), .DEPTH(DEPTH)) u_mem (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_op   (wr_op),
    .wr_mask (wr_mask),
    .wr_next (wr_next),
    .rd_idx  (ptr),
    .rd_op   (cur_op),
    .rd_mask (cur_mask),
    .rd_next (cur_next)
  );

  pseq_pacer #(.DIV_W(DIV_W)) u_pacer (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .run     (run),
    .div_val (div_val),
    .tick    (tick)
  );

  pseq_engine #(.N_OUT(N_OUT), .IDX_W(IDX_W)) u_eng (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .run      (run),
    .tick     (tick),
    .cur_op   (cur_op),
    .cur_mask (cur_mask),
    .cur_next (cur_next),
    .ptr      (ptr),
    .pins     (pins)
  );
endmodule

// File: rtl/pulse_seq_chk.sv
module pulse_seq_chk #(
  parameter int N_OUT = 8,
  parameter int IDX_W = 5,
  parameter int DIV_W = 16
) (
  input logic             clk,
  input logic             rst_s_n,
  input logic             run,
  input logic             tick,
  input logic [DIV_W-1:0] div_val,
  input logic [1:0]       cur_op,
  input logic [N_OUT-1:0] cur_mask,
  input logic [IDX_W-1:0] cur_next,
  input logic [IDX_W-1:0] ptr,
  input logic [N_OUT-1:0] pins
);
  AST_STOP_IDLE: assert property (@(posedge clk) disable iff (!rst_s_n)
    !run |=> (pins == '0) && (ptr == '0)); // R8

  AST_SET_BITS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && cur_op == 2'd1) |=> ((pins & $past(cur_mask)) == $past(cur_mask))); // R2

  AST_CLR_BITS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && cur_op == 2'd2) |=> ((pins & $past(cur_mask)) == '0)); // R2

  AST_QUIET_OPS: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && (cur_op == 2'd0 || cur_op == 2'd3)) |=> $stable(pins)); // R2

  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && cur_op == 2'd3 && !tick) |=> (ptr == $past(ptr))); // R4

  AST_STEP_NEXT: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && (cur_op != 2'd3 || tick)) |=> (ptr == $past(cur_next))); // R3

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_s_n)
    (run && tick && div_val != '0 && $stable(div_val)) |=> !tick); // R4
endmodule

bind pulse_seq pulse_seq_chk #(.N_OUT(N_OUT), .IDX_W(IDX_W), .DIV_W(DIV_W)) u_chk (
  .clk      (clk),
  .rst_s_n  (rst_s_n),
  .run      (run),
  .tick     (tick),
  .div_val  (div_val),
  .cur_op   (cur_op),
  .cur_mask (cur_mask),
  .cur_next (cur_next),
  .ptr      (ptr),
  .pins     (pins)
);

// File: tb/pulse_seq_tb.sv
module pulse_seq_tb;
  logic        clk;
  logic        rst_n;
  logic        run;
  logic [15:0] div_val;
  logic        wr_en;
  logic [4:0]  wr_addr;
  logic [1:0]  wr_op;
  logic [7:0]  wr_mask;
  logic [4:0]  wr_next;
  logic [7:0]  pins;

  int n_chk;
  int n_fail;
  bit done;

  pulse_seq u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .div_val(div_val),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_op(wr_op), .wr_mask(wr_mask),
    .wr_next(wr_next), .pins(pins)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic wr(input int a, input int op, input int m, input int nx);
    wr_en = 1'b1; wr_addr = 5'(a); wr_op = 2'(op); wr_mask = 8'(m); wr_next = 5'(nx);
    step();
    wr_en = 1'b0;
  endtask

  // raise, h stalls, lower, T-h stalls, back to entry 0
  task automatic build(input int h, input int t, input int m);
    wr(0, 1, m, 1);
    for (int i = 1; i <= h; i++) wr(i, 3, 0, i + 1);
    wr(h + 1, 2, m, h + 2);
    for (int i = h + 2; i <= t + 1; i++) wr(i, 3, 0, (i == t + 1) ? 0 : i + 1);
  endtask

  task automatic measure(input int b, input int limit, output int r1, output int f1, output int r2);
    bit prev;
    bit cur;
    r1 = -1; f1 = -1; r2 = -1; prev = 1'b0;
    run = 1'b1;
    for (int n = 1; n <= limit; n++) begin
      step();
      cur = pins[b];
      if (!prev && cur) begin
        if (r1 < 0) r1 = n; else if (r2 < 0) r2 = n;
      end
      if (prev && !cur && f1 < 0) f1 = n;
      prev = cur;
    end
    run = 1'b0;
    step();
    step();
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int r1, f1, r2;
    int qs [4];
    int hs [4];
    int ts [4];
    qs = '{2, 3, 5, 7};
    hs = '{1, 2, 3, 5};
    ts = '{4, 8, 5, 12};
    n_chk = 0; n_fail = 0; done = 1'b0;
    rst_n = 1'b0; run = 1'b0; div_val = '0;
    wr_en = 1'b0; wr_addr = '0; wr_op = '0; wr_mask = '0; wr_next = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (4) step();
    check(pins == 8'h00, "R1 reset pins", pins, 0);

    // R2 / R3: opcode effects and arbitrary next-index chaining
    div_val = 16'd100;
    wr(0, 1, 8'h0F, 7);
    wr(7, 2, 8'h05, 3);
    wr(3, 1, 8'h30, 12);
    wr(12, 0, 8'hFF, 20);
    wr(20, 3, 8'hFF, 20);
    run = 1'b1;
    step(); check(pins == 8'h0F, "R1 entry0 first", pins, 8'h0F);
    step(); check(pins == 8'h0A, "R2 lower via next=7", pins, 8'h0A);
    step(); check(pins == 8'h3A, "R3 raise via next=3", pins, 8'h3A);
    step(); check(pins == 8'h3A, "R2 no-op keeps pins", pins, 8'h3A);
    repeat (5) step();
    check(pins == 8'h3A, "R2 stall keeps pins", pins, 8'h3A);
    run = 1'b0;
    step();

    // R4: two stalls then a raise; raise lands after 2Q+1 cycles
    wr(0, 3, 0, 1);
    wr(1, 3, 0, 2);
    wr(2, 1, 8'h80, 3);
    wr(3, 3, 0, 3);
    for (int q = 1; q <= 8; q++) begin
      div_val = 16'(q - 1);
      run = 1'b1;
      for (int n = 1; n <= 2 * q + 1; n++) begin
        step();
        if (n == 2 * q) check(pins == 8'h00, "R4 before second tick", pins, 0);
        if (n == 2 * q + 1) check(pins == 8'h80, "R4 after second tick", pins, 8'h80);
      end
      run = 1'b0;
      step();
    end

    // R5: width and period sweep
    for (int qi = 0; qi < 4; qi++) begin
      for (int ci = 0; ci < 4; ci++) begin
        div_val = 16'(qs[qi] - 1);
        build(hs[ci], ts[ci], 8'h01);
        measure(0, 2 * ts[ci] * qs[qi] + 5, r1, f1, r2);
        check(r1 == 1, "R1 first rise", r1, 1);
        check(f1 - r1 == hs[ci] * qs[qi], "R5 high time", f1 - r1, hs[ci] * qs[qi]);
        check(r2 - r1 == ts[ci] * qs[qi], "R5 period", r2 - r1, ts[ci] * qs[qi]);
      end
    end

    // R6: two pins from one list, Q=3
    div_val = 16'd2;
    wr(0, 1, 8'h03, 1);
    wr(1, 3, 0, 2);
    wr(2, 3, 0, 3);
    wr(3, 2, 8'h01, 4);
    wr(4, 3, 0, 5);
    wr(5, 3, 0, 6);
    wr(6, 3, 0, 7);
    wr(7, 2, 8'h02, 8);
    wr(8, 3, 0, 9);
    wr(9, 3, 0, 10);
    wr(10, 3, 0, 11);
    wr(11, 3, 0, 0);
    measure(0, 60, r1, f1, r2);
    check(r1 == 1, "R6 pin0 rise", r1, 1);
    check(f1 - r1 == 6, "R6 pin0 high", f1 - r1, 6);
    check(r2 - r1 == 27, "R6 pin0 period", r2 - r1, 27);
    measure(1, 60, r1, f1, r2);
    check(r1 == 1, "R6 pin1 rise", r1, 1);
    check(f1 - r1 == 15, "R6 pin1 high", f1 - r1, 15);
    check(r2 - r1 == 27, "R6 pin1 period", r2 - r1, 27);

    // R7: rewrite entry 2 (stall -> no-op) during the low phase, Q=3
    begin
      int rr [3];
      int ff [3];
      int nr, nf;
      bit prev, cur, wrote;
      div_val = 16'd2;
      build(2, 8, 8'h04);
      nr = 0; nf = 0; prev = 1'b0; wrote = 1'b0;
      rr = '{0, 0, 0}; ff = '{0, 0, 0};
      run = 1'b1;
      for (int n = 1; n <= 70; n++) begin
        step();
        if (wr_en) wr_en = 1'b0;
        cur = pins[2];
        if (!prev && cur && nr < 3) begin rr[nr] = n; nr++; end
        if (prev && !cur && nf < 3) begin ff[nf] = n; nf++; end
        if (nf == 1 && !wrote) begin
          wrote = 1'b1;
          wr_en = 1'b1; wr_addr = 5'd2; wr_op = 2'd0; wr_mask = 8'h00; wr_next = 5'd3;
        end
        prev = cur;
      end
      run = 1'b0;
      step();
      check(rr[0] == 1, "R7 first rise", rr[0], 1);
      check(ff[0] - rr[0] == 6, "R7 old high", ff[0] - rr[0], 6);
      check(rr[1] - rr[0] == 24, "R7 old period", rr[1] - rr[0], 24);
      check(ff[1] - rr[1] == 4, "R7 new high", ff[1] - rr[1], 4);
      check(rr[2] - rr[1] == 21, "R7 new period", rr[2] - rr[1], 21);
    end

    // R8: stop mid-pulse, then restart from scratch, Q=4
    div_val = 16'd3;
    build(3, 6, 8'h01);
    run = 1'b1;
    repeat (5) step();
    check(pins == 8'h01, "R8 high before stop", pins, 1);
    run = 1'b0;
    step();
    check(pins == 8'h00, "R8 low after stop", pins, 0);
    repeat (3) step();
    check(pins == 8'h00, "R8 stays low", pins, 0);
    measure(0, 60, r1, f1, r2);
    check(r1 == 1, "R8 restart at entry 0", r1, 1);
    check(f1 - r1 == 12, "R8 restart high", f1 - r1, 12);
    check(r2 - r1 == 24, "R8 restart period", r2 - r1, 24);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule